// File: doc/BRIEF.md
# Cycle-Counted Instruction Fetch Sequencer

This block runs a small subset of an 8-bit accumulator instruction set one clock tick at a time. It owns the program counter, the accumulator, a status byte and a down-counter of remaining execution steps. All memory traffic goes through a single synchronous byte-read port. The block drives an address, and the byte at that address arrives on the read-data input one clock later.

After reset the block reads four bytes from the top of the address space. The word at 0xFFFC/0xFFFD becomes the program counter, and the word at 0xFFFE/0xFFFF is held in an interrupt vector register. Each byte is read as low byte first. After that the block loops. While the step counter is zero it reads the opcode and two following bytes at the PC. It then decodes them, advances the PC by the instruction length, and loads the counter with the instruction's cycle count. Each later tick decrements the counter, and the instruction's effect is applied on the tick that takes the counter from 1 to 0. The counter is exported so that an observer can follow the steps.

Top module: `fsq_sequencer`

## Requirements
- R1: Reset is synchronous and active high. It clears the PC, accumulator, status and step count to zero. Five clock edges after reset is released, the PC holds the little-endian word at 0xFFFC (low) and 0xFFFD (high).
- R2: By the same fifth edge, the interrupt vector output holds the little-endian word at 0xFFFE (low) and 0xFFFF (high). It then stays unchanged while instructions execute.
- R3: With the step count at zero, the block spends three fetch cycles and one decode cycle. On the fourth edge it loads the step count with the opcode's cycle count: 0xEA NOP 2, 0xA9 load-immediate 2, 0xA5 load-zero-page 3, 0x18/0x38/0x58/0x78/0xD8/0xF8/0xB8 flag operations 2, 0x6A rotate-accumulator 2, 0x4C jump-absolute 3.
- R4: At that same decode edge the PC advances by the instruction length. The length is 1 for NOP, the flag operations and the rotate, 2 for both loads, and 3 for the jump. The PC does not change while more than one step remains.
- R5: While the step count is nonzero, every clock edge lowers it by exactly one. The next fetch begins once it reaches zero.
- R6: A 3-byte instruction takes its operand little-endian, with the first operand byte as the low byte. Jump-absolute loads that operand into the PC on its last step.
- R7: Load-immediate puts the operand byte in the accumulator. Load-zero-page puts in the accumulator the byte read from address 0x00nn, where nn is the operand.
- R8: Rotate-accumulator (0x6A) rotates the accumulator right by one bit, with bit 0 going to bit 7. The status byte plays no part.
- R9: Flag operations set or clear single status bits: carry at bit 0 (0x18 clear, 0x38 set), interrupt-disable at bit 2 (0x58 clear, 0x78 set), decimal at bit 3 (0xD8 clear, 0xF8 set), and overflow at bit 6 (0xB8 clear).
- R10: Any other opcode decodes as NOP, taking 1 byte and 2 cycles and leaving the accumulator and status unchanged.
- R11: The remaining step count is driven as an 8-bit output at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address presented to the read port |
| mem_rdata | input | 8 | Byte read from the address given one cycle earlier |
| pc_o | output | 16 | Program counter |
| ivec_o | output | 16 | Interrupt vector register |
| acc_o | output | 8 | Accumulator |
| status_o | output | 8 | Status byte (C bit 0, I bit 2, D bit 3, V bit 6) |
| steps_left | output | 8 | Remaining execution steps of the current instruction |

## Verification
A program of fifteen instructions runs from the reset vector. Its lengths are 1, 2 and 3 bytes and its cycle counts are 2 and 3, so a wrong PC step or a wrong counter load puts every later sample out of step. The accumulator sequence 0x96, 0x4B, 0xA5 is chosen so that the rotate moves set bits across both ends, and set and clear operations on three flags build up and then take down a status pattern one bit at a time. An unknown opcode and a jump whose operand bytes differ (0x00, 0x90) separate a NOP fallback from a misdecode and separate little-endian from big-endian assembly. A second reset taken in the middle of an instruction, with new vectors, shows that the state is cleared and the vectors are fetched again.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 8;

    localparam int ST_BIT_CARRY = 0;
    localparam int ST_BIT_IRQD  = 2;
    localparam int ST_BIT_DEC   = 3;
    localparam int ST_BIT_OVF   = 6;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LD_IMM,
        OP_LD_ZP,
        OP_CLR_C,
        OP_SET_C,
        OP_CLR_I,
        OP_SET_I,
        OP_CLR_D,
        OP_SET_D,
        OP_CLR_V,
        OP_ROT_R,
        OP_JUMP
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [1:0]       len;
        logic [CNT_W-1:0] cycles;
    } op_info_t;

    typedef struct packed {
        op_e               op;
        logic [WORD_W-1:0] arg;
    } instr_t;

    typedef enum logic [3:0] {
        S_VEC0,
        S_VEC1,
        S_VEC2,
        S_VEC3,
        S_VEC4,
        S_FET0,
        S_FET1,
        S_FET2,
        S_DEC,
        S_EXEC
    } seq_state_e;

    function automatic op_info_t lookup_op(input logic [BYTE_W-1:0] opcode);
        op_info_t r;
        r = '{op: OP_NOP, len: 2'd1, cycles: CNT_W'(2)};
        case (opcode)
            8'hEA: r = '{op: OP_NOP,    len: 2'd1, cycles: CNT_W'(2)};
            8'hA9: r = '{op: OP_LD_IMM, len: 2'd2, cycles: CNT_W'(2)};
            8'hA5: r = '{op: OP_LD_ZP,  len: 2'd2, cycles: CNT_W'(3)};
            8'h18: r = '{op: OP_CLR_C,  len: 2'd1, cycles: CNT_W'(2)};
            8'h38: r = '{op: OP_SET_C,  len: 2'd1, cycles: CNT_W'(2)};
            8'h58: r = '{op: OP_CLR_I,  len: 2'd1, cycles: CNT_W'(2)};
            8'h78: r = '{op: OP_SET_I,  len: 2'd1, cycles: CNT_W'(2)};
            8'hD8: r = '{op: OP_CLR_D,  len: 2'd1, cycles: CNT_W'(2)};
            8'hF8: r = '{op: OP_SET_D,  len: 2'd1, cycles: CNT_W'(2)};
            8'hB8: r = '{op: OP_CLR_V,  len: 2'd1, cycles: CNT_W'(2)};
            8'h6A: r = '{op: OP_ROT_R,  len: 2'd1, cycles: CNT_W'(2)};
            8'h4C: r = '{op: OP_JUMP,   len: 2'd3, cycles: CNT_W'(3)};
            default: r = '{op: OP_NOP,  len: 2'd1, cycles: CNT_W'(2)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsq_decoder.sv
module fsq_decoder
    import fsq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] byte_lo,
    input  logic [BYTE_W-1:0] byte_hi,
    output op_info_t          info,
    output instr_t            instr
);
    always_comb begin
        info     = lookup_op(opcode);
        instr.op = info.op;
        case (info.len)
            2'd3:    instr.arg = {byte_hi, byte_lo};
            2'd2:    instr.arg = {{(WORD_W-BYTE_W){1'b0}}, byte_lo};
            default: instr.arg = '0;
        endcase
    end
endmodule

// File: rtl/fsq_exec.sv
module fsq_exec
    import fsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  op_e               op,
    input  logic [BYTE_W-1:0] arg_lo,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] acc,
    output logic [BYTE_W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            status <= '0;
        end else if (fire) begin
            case (op)
                OP_LD_IMM: acc <= arg_lo;
                OP_LD_ZP:  acc <= rd_byte;
                OP_ROT_R:  acc <= {acc[0], acc[BYTE_W-1:1]};
                OP_CLR_C:  status[ST_BIT_CARRY] <= 1'b0;
                OP_SET_C:  status[ST_BIT_CARRY] <= 1'b1;
                OP_CLR_I:  status[ST_BIT_IRQD]  <= 1'b0;
                OP_SET_I:  status[ST_BIT_IRQD]  <= 1'b1;
                OP_CLR_D:  status[ST_BIT_DEC]   <= 1'b0;
                OP_SET_D:  status[ST_BIT_DEC]   <= 1'b1;
                OP_CLR_V:  status[ST_BIT_OVF]   <= 1'b0;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/fsq_sequencer.sv
module fsq_sequencer
    import fsq_pkg::*;
#(
    parameter logic [15:0] RESET_VEC_ADDR = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC_ADDR   = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_o,
    output logic [15:0] ivec_o,
    output logic [7:0]  acc_o,
    output logic [7:0]  status_o,
    output logic [7:0]  steps_left
);
    localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO_W = WORD_W'(2);

    seq_state_e        state;
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] ivec;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] opcode_q;
    logic [BYTE_W-1:0] byte1_q;
    instr_t            ir;
    op_info_t          dec_info;
    instr_t            dec_instr;
    logic              fire;

    fsq_decoder u_dec (
        .opcode  (opcode_q),
        .byte_lo (byte1_q),
        .byte_hi (mem_rdata),
        .info    (dec_info),
        .instr   (dec_instr)
    );

    assign fire = (state == S_EXEC) && (cnt == CNT_W'(1));

    fsq_exec u_exec (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .op      (ir.op),
        .arg_lo  (ir.arg[BYTE_W-1:0]),
        .rd_byte (mem_rdata),
        .acc     (acc_o),
        .status  (status_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_VEC0;
            pc       <= '0;
            ivec     <= '0;
            cnt      <= '0;
            opcode_q <= '0;
            byte1_q  <= '0;
            ir       <= '{op: OP_NOP, arg: '0};
        end else begin
            case (state)
                S_VEC0: state <= S_VEC1;
                S_VEC1: begin
                    pc[BYTE_W-1:0] <= mem_rdata;
                    state <= S_VEC2;
                end
                S_VEC2: begin
                    pc[WORD_W-1:BYTE_W] <= mem_rdata;
                    state <= S_VEC3;
                end
                S_VEC3: begin
                    ivec[BYTE_W-1:0] <= mem_rdata;
                    state <= S_VEC4;
                end
                S_VEC4: begin
                    ivec[WORD_W-1:BYTE_W] <= mem_rdata;
                    state <= S_FET0;
                end
                S_FET0: state <= S_FET1;
                S_FET1: begin
                    opcode_q <= mem_rdata;
                    state <= S_FET2;
                end
                S_FET2: begin
                    byte1_q <= mem_rdata;
                    state <= S_DEC;
                end
                S_DEC: begin
                    ir    <= dec_instr;
                    pc    <= pc + WORD_W'(dec_info.len);
                    cnt   <= dec_info.cycles;
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1)) begin
                        if (ir.op == OP_JUMP) pc <= ir.arg;
                        state <= S_FET0;
                    end
                end
                default: state <= S_VEC0;
            endcase
        end
    end

    always_comb begin
        case (state)
            S_VEC0:  mem_addr = RESET_VEC_ADDR;
            S_VEC1:  mem_addr = RESET_VEC_ADDR + ONE_W;
            S_VEC2:  mem_addr = IRQ_VEC_ADDR;
            S_VEC3:  mem_addr = IRQ_VEC_ADDR + ONE_W;
            S_FET0:  mem_addr = pc;
            S_FET1:  mem_addr = pc + ONE_W;
            S_FET2:  mem_addr = pc + TWO_W;
            S_EXEC:  mem_addr = (ir.op == OP_LD_ZP) ?
                                {{(WORD_W-BYTE_W){1'b0}}, ir.arg[BYTE_W-1:0]} : pc;
            default: mem_addr = pc;
        endcase
    end

    assign pc_o       = pc;
    assign ivec_o     = ivec;
    assign steps_left = cnt;

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] pc,
    input logic [15:0] ivec,
    input logic [7:0]  acc,
    input logic [7:0]  steps
);
    AST_STEP_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (steps != 8'd0) |=> (steps == $past(steps) - 8'd1)); // R5

    AST_STEP_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (steps == 8'd0) |=> (steps == 8'd0 || steps == 8'd2 || steps == 8'd3)); // R3

    AST_PC_HELD_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        (steps > 8'd1) |=> $stable(pc)); // R4

    AST_ACC_HELD_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (steps == 8'd0) |=> $stable(acc)); // R7

    AST_IVEC_HELD_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        (steps != 8'd0) |=> $stable(ivec)); // R2
endmodule

bind fsq_sequencer fsq_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_o),
    .ivec  (ivec_o),
    .acc   (acc_o),
    .steps (steps_left)
);

// File: tb/tb_fsq_sequencer.sv
module tb_fsq_sequencer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 15;

    typedef struct packed {
        logic [15:0] pc_dec;
        logic [7:0]  cyc;
        logic [15:0] pc_end;
        logic [7:0]  acc;
        logic [7:0]  st;
    } vec_t;

    // Program at 0x8000 then 0x9000; one row per instruction.
    localparam vec_t VECS [NVEC] = '{
        '{16'h8001, 8'd2, 16'h8001, 8'h00, 8'h00},  // EA NOP
        '{16'h8003, 8'd2, 16'h8003, 8'h96, 8'h00},  // A9 96
        '{16'h8004, 8'd2, 16'h8004, 8'h4B, 8'h00},  // 6A rotate
        '{16'h8005, 8'd2, 16'h8005, 8'h4B, 8'h01},  // 38 set C
        '{16'h8006, 8'd2, 16'h8006, 8'hA5, 8'h01},  // 6A rotate
        '{16'h8007, 8'd2, 16'h8007, 8'hA5, 8'h09},  // F8 set D
        '{16'h8008, 8'd2, 16'h8008, 8'hA5, 8'h0D},  // 78 set I
        '{16'h800A, 8'd3, 16'h800A, 8'hC3, 8'h0D},  // A5 40 zero page
        '{16'h800B, 8'd2, 16'h800B, 8'hC3, 8'h0C},  // 18 clear C
        '{16'h800C, 8'd2, 16'h800C, 8'hC3, 8'h04},  // D8 clear D
        '{16'h800D, 8'd2, 16'h800D, 8'hC3, 8'h00},  // 58 clear I
        '{16'h800E, 8'd2, 16'h800E, 8'hC3, 8'h00},  // FF unknown, R10
        '{16'h8011, 8'd3, 16'h9000, 8'hC3, 8'h00},  // 4C 00 90 jump, R6
        '{16'h9002, 8'd2, 16'h9002, 8'h5A, 8'h00},  // A9 5A
        '{16'h9003, 8'd2, 16'h9003, 8'h5A, 8'h00}   // B8 clear V
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_o, ivec_o;
    logic [7:0]  acc_o, status_o, steps_left;

    logic [7:0] m_zp  [256];
    logic [7:0] m_p80 [256];
    logic [7:0] m_p90 [256];
    logic [7:0] m_pff [256];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        case (mem_addr[15:8])
            8'h00:   mem_rdata <= m_zp[mem_addr[7:0]];
            8'h80:   mem_rdata <= m_p80[mem_addr[7:0]];
            8'h90:   mem_rdata <= m_p90[mem_addr[7:0]];
            8'hFF:   mem_rdata <= m_pff[mem_addr[7:0]];
            default: mem_rdata <= 8'h00;
        endcase
    end

    fsq_sequencer dut (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .pc_o       (pc_o),
        .ivec_o     (ivec_o),
        .acc_o      (acc_o),
        .status_o   (status_o),
        .steps_left (steps_left)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_zp[i] = 8'h00; m_p80[i] = 8'h00; m_p90[i] = 8'h00; m_pff[i] = 8'h00;
        end
        m_pff[8'hFC] = 8'h00; m_pff[8'hFD] = 8'h80;
        m_pff[8'hFE] = 8'h34; m_pff[8'hFF] = 8'h12;
        m_zp[8'h40] = 8'hC3;
        m_p80[8'h00] = 8'hEA; m_p80[8'h01] = 8'hA9; m_p80[8'h02] = 8'h96;
        m_p80[8'h03] = 8'h6A; m_p80[8'h04] = 8'h38; m_p80[8'h05] = 8'h6A;
        m_p80[8'h06] = 8'hF8; m_p80[8'h07] = 8'h78; m_p80[8'h08] = 8'hA5;
        m_p80[8'h09] = 8'h40; m_p80[8'h0A] = 8'h18; m_p80[8'h0B] = 8'hD8;
        m_p80[8'h0C] = 8'h58; m_p80[8'h0D] = 8'hFF; m_p80[8'h0E] = 8'h4C;
        m_p80[8'h0F] = 8'h00; m_p80[8'h10] = 8'h90;
        m_p90[8'h00] = 8'hA9; m_p90[8'h01] = 8'h5A; m_p90[8'h02] = 8'hB8;

        // Reset state, R1 and R11
        wait_edges(3);
        chk("R1 pc in reset", pc_o, 16'h0000);
        chk("R11 steps in reset", {8'h00, steps_left}, 16'h0000);
        chk("R1 acc in reset", {8'h00, acc_o}, 16'h0000);
        rst = 1'b0;
        wait_edges(5);
        chk("R1 pc from reset vector", pc_o, 16'h8000);
        chk("R2 ivec from vector", ivec_o, 16'h1234);
        chk("R11 steps idle", {8'h00, steps_left}, 16'h0000);

        // Program walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            wait_edges(4);
            chk($sformatf("R3 steps after decode #%0d", v), {8'h00, steps_left}, {8'h00, VECS[v].cyc});
            chk($sformatf("R4 pc after decode #%0d", v), pc_o, VECS[v].pc_dec);
            wait_edges(1);
            chk($sformatf("R5 steps decrement #%0d", v), {8'h00, steps_left}, {8'h00, VECS[v].cyc - 8'd1});
            wait_edges(int'(VECS[v].cyc) - 1);
            chk($sformatf("R5 steps zero #%0d", v), {8'h00, steps_left}, 16'h0000);
            chk($sformatf("R6 pc after exec #%0d", v), pc_o, VECS[v].pc_end);
            chk($sformatf("R7 R8 acc #%0d", v), {8'h00, acc_o}, {8'h00, VECS[v].acc});
            chk($sformatf("R9 status #%0d", v), {8'h00, status_o}, {8'h00, VECS[v].st});
            chk($sformatf("R2 ivec held #%0d", v), ivec_o, 16'h1234);
        end

        // Unknown opcode 0x00 at 0x9003: R10
        wait_edges(4);
        chk("R10 unknown steps", {8'h00, steps_left}, 16'h0002);
        chk("R10 unknown length", pc_o, 16'h9004);
        wait_edges(1);
        chk("R10 acc untouched", {8'h00, acc_o}, 16'h005A);

        // Reset mid-instruction with new vectors: R1 R2
        m_pff[8'hFC] = 8'h02; m_pff[8'hFD] = 8'h90;
        m_pff[8'hFE] = 8'hFF; m_pff[8'hFF] = 8'h00;
        rst = 1'b1;
        wait_edges(1);
        chk("R1 steps cleared mid-run", {8'h00, steps_left}, 16'h0000);
        chk("R1 acc cleared mid-run", {8'h00, acc_o}, 16'h0000);
        chk("R1 pc cleared mid-run", pc_o, 16'h0000);
        rst = 1'b0;
        wait_edges(5);
        chk("R1 pc from new vector", pc_o, 16'h9002);
        chk("R2 ivec from new vector", ivec_o, 16'h00FF);
        wait_edges(4);
        chk("R3 steps after re-reset decode", {8'h00, steps_left}, 16'h0002);
        chk("R4 pc after re-reset decode", pc_o, 16'h9003);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule